// File: doc/BRIEF.md
# Shared-Ring SPI Flash Command Engine

This block is a register-mapped SPI master that runs one serial-flash command at a time. Software loads a one-byte command code, a packed byte holding how many payload bytes to send and how many response bytes to collect, and the payload itself. Then it sets a self-clearing start bit. The engine lowers chip select and sends the command code, then the payload. It keeps clocking to collect the response and raises chip select after the last bit.

Payload and response share one eight-entry circular byte store. A single pointer, visible to software, steps through it. The data port reads or writes the entry at the pointer and then advances the pointer. While the command runs, every byte shifted in after the command code overwrites the entry at the pointer, which then advances. This includes the bytes shifted in while the payload is going out. After a run, the response therefore begins at the index equal to the payload count. The store is never cleared. Software rewinds the pointer through a control bit before it loads the payload and again before it reads the response. A two-bit field divides the serial clock from the system clock.

Top module: `spi_ring_engine`

## Requirements
- R1: After reset, the command, count, control and status registers read 0x00, `spiCsN` is 1, and `spiSck` and `spiMosi` are 0.
- R2: The command code register (offset 0x0) always goes out first, MSB first, in SPI mode 0. `spiMosi` changes only while `spiSck` is low, and the slave samples it on the rising edge. The command code never passes through the ring.
- R3: Payload byte k (k = 1..W, where W is bits 3:0 of the count register at offset 0x1) is taken from the ring entry at the pointer as it stands when that byte begins. During the R response bytes (R is bits 7:4 of offset 0x1), `spiMosi` is held at 0.
- R4: Each of the W+R bytes shifted in from `spiMiso` after the command code is written to the ring at the pointer, and the pointer then advances. When the run ends, the pointer equals (start pointer + W + R) mod 8.
- R5: With W = 0, all R response bytes are still captured. None is dropped.
- R6: Rewinding the pointer and running commands never clear the ring. Entries that a run does not reach keep their old values.
- R7: Each read or write access to the data port (offset 0xC) touches the entry at the pointer and then advances the pointer by one modulo 8.
- R8: Writing 1 to bit 4 of the control register (offset 0x2) sets the pointer to 0. The pointer reads back in bits 2:0 of the status register (offset 0xD).
- R9: Writing 1 to bit 0 of offset 0x2 while idle starts a run. That bit reads 1 while the run is in progress and 0 once it has ended.
- R10: The count register holds its programmed value through and after a run.
- R11: Bits 5:4 of offset 0xD (value N, readable) set each half period of `spiSck` to N+1 system clocks. A run of B bytes (B = 1+W+R) therefore keeps chip select low for 16·B·(N+1) clocks.
- R12: While a run is in progress, host writes to any register are ignored, and data port accesses do not move the pointer.
- R13: `spiCsN` is low from the first command bit to the last response bit, with exactly 8·B rising `spiSck` edges inside that window. `spiSck` is low whenever `spiCsN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (advances the pointer at offset 0xC) |
| busAddr | input | 4 | Register byte offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
Four commands are used. A command-code-only run shows that the ring stays untouched and the pointer does not move. A zero-payload read shows that no response byte is dropped. A short write-then-read separates payload bytes that are fetched from the ring from response bytes that are stored back into it. A long run whose response wraps past entry 7 tests the modulo pointer on the capture path. That long run is also interrupted by host writes to every register, which shows they are ignored. Each run uses a different rate code, so the measured chip-select window tells the four divisions apart. A behavioural slave feeds an index-dependent response. Entries that a run never reaches are checked against their earlier values.

// File: rtl/spi_ring_pkg.sv
package spi_ring_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int RATE_W  = 2;
  localparam int RING_D  = 8;
  localparam int PTR_W   = $clog2(RING_D);
  localparam int BIDX_W  = CNT_W + 1;

  localparam logic [3:0] OFS_CMD   = 4'h0;
  localparam logic [3:0] OFS_COUNT = 4'h1;
  localparam logic [3:0] OFS_CTRL  = 4'h2;
  localparam logic [3:0] OFS_DATA  = 4'hC;
  localparam logic [3:0] OFS_STAT  = 4'hD;

  typedef struct packed {
    logic launch;     // start accepted this cycle
    logic sampleIn;   // rising SCK: capture one MISO bit
    logic shiftOut;   // falling SCK inside a byte: next MOSI bit
    logic storeRx;    // byte finished after the command code: write ring
    logic loadTx;     // byte finished, another follows: load next byte
    logic txFromBuf;  // next byte comes from the ring (else zero)
  } engStrobe_t;
endpackage

// File: rtl/spi_ring_ctrl.sv
module spi_ring_ctrl
  import spi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [CNT_W-1:0]  rdCount,
  input  logic [RATE_W-1:0] rateSel,
  output engStrobe_t        stb,
  output logic              busy,
  output logic              sck,
  output logic              csN
);
  logic              running;
  logic [RATE_W-1:0] tickCnt;
  logic              sckQ;
  logic [2:0]        bitCnt;
  logic [BIDX_W-1:0] byteCnt;
  logic [BIDX_W-1:0] lastIdx;
  logic tick, rising, falling, byteEnd;

  assign lastIdx = BIDX_W'(wrCount) + BIDX_W'(rdCount);
  assign tick    = running && (tickCnt == rateSel);
  assign rising  = tick && !sckQ;
  assign falling = tick && sckQ;
  assign byteEnd = falling && (bitCnt == 3'd7);

  always_comb begin
    stb.launch    = startReq && !running;
    stb.sampleIn  = rising;
    stb.shiftOut  = falling && (bitCnt != 3'd7);
    stb.storeRx   = byteEnd && (byteCnt != '0);
    stb.loadTx    = byteEnd && (byteCnt != lastIdx);
    stb.txFromBuf = byteCnt < BIDX_W'(wrCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      tickCnt <= '0;
      sckQ    <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (stb.launch) begin
      running <= 1'b1;
      tickCnt <= '0;
      sckQ    <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (running) begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (tick) sckQ <= !sckQ;
      if (falling) bitCnt <= bitCnt + 1'b1;
      if (byteEnd) begin
        byteCnt <= byteCnt + 1'b1;
        if (byteCnt == lastIdx) begin
          running <= 1'b0;
          sckQ    <= 1'b0;
        end
      end
    end
  end

  assign busy = running;
  assign sck  = sckQ;
  assign csN  = !running;
endmodule

// File: rtl/spi_ring_dp.sv
module spi_ring_dp
  import spi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [3:0]        busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              miso,
  output logic              mosi,
  input  logic              busy,
  input  engStrobe_t        stb,
  output logic              startReq,
  output logic [CNT_W-1:0]  wrCount,
  output logic [CNT_W-1:0]  rdCount,
  output logic [RATE_W-1:0] rateSel
);
  logic [BYTE_W-1:0] opcodeQ;
  logic [BYTE_W-1:0] countQ;
  logic [RATE_W-1:0] rateQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [PTR_W-1:0]  ptrNext;
  logic [BYTE_W-1:0] ring [RING_D];
  logic [BYTE_W-1:0] txSh;
  logic [BYTE_W-1:0] rxSh;
  logic hostWr, dataWr, dataTouch, ptrClear;

  assign hostWr    = busWrEn && !busy;
  assign dataWr    = hostWr && (busAddr == OFS_DATA);
  assign dataTouch = !busy && (busAddr == OFS_DATA) && (busWrEn || busRdEn);
  assign ptrClear  = hostWr && (busAddr == OFS_CTRL) && busWrData[4];
  assign startReq  = hostWr && (busAddr == OFS_CTRL) && busWrData[0];
  assign ptrNext   = stb.storeRx ? ptrQ + 1'b1 : ptrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ <= '0;
      countQ  <= '0;
      rateQ   <= '0;
    end else if (hostWr) begin
      if (busAddr == OFS_CMD)   opcodeQ <= busWrData;
      if (busAddr == OFS_COUNT) countQ  <= busWrData;
      if (busAddr == OFS_STAT)  rateQ   <= busWrData[5:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ptrQ <= '0;
    else if (stb.storeRx) ptrQ <= ptrQ + 1'b1;
    else if (ptrClear)    ptrQ <= '0;
    else if (dataTouch)   ptrQ <= ptrQ + 1'b1;
  end

  // Ring contents have no reset: they persist by design.
  always_ff @(posedge clk) begin
    if (stb.storeRx)  ring[ptrQ] <= rxSh;
    else if (dataWr)  ring[ptrQ] <= busWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (stb.launch)        txSh <= opcodeQ;
      else if (stb.loadTx)   txSh <= stb.txFromBuf ? ring[ptrNext] : '0;
      else if (stb.shiftOut) txSh <= {txSh[BYTE_W-2:0], 1'b0};
      if (stb.sampleIn)      rxSh <= {rxSh[BYTE_W-2:0], miso};
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CMD:   busRdData = opcodeQ;
      OFS_COUNT: busRdData = countQ;
      OFS_CTRL:  busRdData = {7'b0, busy};
      OFS_DATA:  busRdData = ring[ptrQ];
      OFS_STAT:  busRdData = BYTE_W'({rateQ, 1'b0, ptrQ});
      default:   busRdData = '0;
    endcase
  end

  assign mosi    = busy && txSh[BYTE_W-1];
  assign wrCount = countQ[CNT_W-1:0];
  assign rdCount = countQ[BYTE_W-1:CNT_W];
  assign rateSel = rateQ;
endmodule

// File: rtl/spi_ring_engine.sv
module spi_ring_engine
  import spi_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);
  engStrobe_t        stb;
  logic              busy, startReq;
  logic [CNT_W-1:0]  wrCount, rdCount;
  logic [RATE_W-1:0] rateSel;

  spi_ring_dp u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .miso(spiMiso), .mosi(spiMosi), .busy(busy), .stb(stb),
    .startReq(startReq), .wrCount(wrCount), .rdCount(rdCount), .rateSel(rateSel)
  );

  spi_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrCount(wrCount),
    .rdCount(rdCount), .rateSel(rateSel), .stb(stb), .busy(busy),
    .sck(spiSck), .csN(spiCsN)
  );
endmodule

// File: rtl/spi_ring_engine_chk.sv
module spi_ring_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWrEn,
  input logic [3:0] busAddr,
  input logic [7:0] busWrData,
  input logic       spiSck,
  input logic       spiCsN,
  input logic       busy,
  input logic [7:0] opcodeQ,
  input logic [7:0] countQ,
  input logic [2:0] ptrQ
);
  assert_sck_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  assert_cs_from_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> $past(busWrEn && busAddr == 4'h2 && busWrData[0]));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(countQ));

  assert_cmd_locked_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(opcodeQ));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busWrEn && busAddr == 4'hC) |=> ptrQ == 3'($past(ptrQ) + 3'd1));

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busWrEn && busAddr == 4'h2 && busWrData[4]) |=> ptrQ == 3'd0);
endmodule

bind spi_ring_engine spi_ring_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .spiSck(spiSck), .spiCsN(spiCsN),
  .busy(u_ctrl.running), .opcodeQ(u_dp.opcodeQ), .countQ(u_dp.countQ),
  .ptrQ(u_dp.ptrQ)
);

// File: tb/spi_ring_engine_tb.sv
module spi_ring_engine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       spiSck, spiCsN, spiMosi, spiMiso;

  int vecCnt = 0;
  int errCnt = 0;

  always #4 clk = !clk;

  spi_ring_engine u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---------------- behavioural flash slave ----------------
  logic [7:0] seed = 8'h00;
  int sBit = 0;
  function automatic logic [7:0] respByte(int k);
    return 8'(k * 59) ^ seed ^ 8'h5A;
  endfunction
  always @(negedge spiCsN) sBit = 0;
  always @(negedge spiSck) if (!spiCsN) sBit = sBit + 1;
  always_comb begin
    logic [7:0] b;
    b = respByte(sBit / 8);
    spiMiso = b[7 - (sBit % 8)];
  end

  logic [7:0] capB [32];
  int capN = 0;
  int lowCyc = 0;
  always @(posedge spiSck) if (!spiCsN) begin
    capB[capN / 8] = {capB[capN / 8][6:0], spiMosi};
    capN = capN + 1;
  end
  always @(negedge clk) if (!spiCsN) lowCyc = lowCyc + 1;

  // ---------------- reference model ----------------
  logic [7:0] mBuf [8];
  int mPtr = 0;

  task automatic chkEq(input string tag, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic hostData(input logic [7:0] d);
    busWrite(4'hC, d);
    mBuf[mPtr] = d;
    mPtr = (mPtr + 1) % 8;
  endtask

  task automatic rewind();
    busWrite(4'h2, 8'h10);
    mPtr = 0;
  endtask

  task automatic dumpRing(input string tag);
    logic [7:0] d;
    rewind();
    for (int i = 0; i < 8; i++) begin
      busRead(4'hC, d);
      chkEq(tag, d, mBuf[i]);
    end
    busRead(4'hD, d);
    chkEq("R7", d[2:0], 0);
  endtask

  task automatic runCmd(input logic [7:0] op, input int wr, input int rd,
                        input int rate, input logic [7:0] sd, input bit poke);
    logic [7:0] expTx [32];
    logic [7:0] d;
    int nB, guard;
    nB = 1 + wr + rd;
    seed = sd;
    busWrite(4'hD, 8'(rate << 4));
    busWrite(4'h0, op);
    busWrite(4'h1, 8'((rd << 4) | wr));
    rewind();
    for (int i = 0; i < wr; i++) hostData(8'hC0 + 8'(i * 7) + sd);
    rewind();
    expTx[0] = op;
    for (int k = 1; k < nB; k++) begin
      expTx[k] = (k <= wr) ? mBuf[mPtr] : 8'h00;
      mBuf[mPtr] = respByte(k);
      mPtr = (mPtr + 1) % 8;
    end
    capN = 0; lowCyc = 0;
    busWrite(4'h2, 8'h01);
    if (poke) begin
      busWrite(4'h0, 8'hEE);
      busWrite(4'h1, 8'h77);
      busWrite(4'hC, 8'h99);
      busWrite(4'hD, 8'h00);
      busWrite(4'h2, 8'h10);
    end
    busRead(4'h2, d);
    chkEq("R9 busy", d, 8'h01);
    guard = 0;
    while (d[0] && guard < 5000) begin
      busRead(4'h2, d);
      guard++;
    end
    chkEq("R9 done", d, 8'h00);
    chkEq("R11 window", lowCyc, 16 * nB * (rate + 1));
    chkEq("R13 edges", capN, 8 * nB);
    chkEq("R13 idle", {spiCsN, spiSck}, 2'b10);
    chkEq("R2 opcode", capB[0], op);
    for (int k = 1; k < nB; k++) chkEq("R3 mosi", capB[k], expTx[k]);
    busRead(4'hD, d);
    chkEq("R4 ptr", d[2:0], (wr + rd) % 8);
    chkEq("R11 rate", d[5:4], rate);
    busRead(4'h1, d);
    chkEq("R10 count", d, (rd << 4) | wr);
    busRead(4'h0, d);
    chkEq("R12 opcode", d, op);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead(4'h0, d); chkEq("R1 cmd", d, 0);
    busRead(4'h1, d); chkEq("R1 count", d, 0);
    busRead(4'h2, d); chkEq("R1 ctrl", d, 0);
    busRead(4'hD, d); chkEq("R1 stat", d, 0);
    chkEq("R1 pins", {spiCsN, spiSck, spiMosi}, 3'b100);

    // R7 wrap of the data port, R8 rewind
    rewind();
    for (int i = 0; i < 10; i++) hostData(8'h10 + 8'(i));
    busRead(4'hD, d); chkEq("R7 wrap", d[2:0], 2);
    busWrite(4'h2, 8'h10);
    busRead(4'hD, d); chkEq("R8 rewind", d[2:0], 0);
    mPtr = 0;
    dumpRing("R7 ring");

    // R5 zero payload read
    runCmd(8'h9F, 0, 3, 0, 8'h21, 1'b0);
    dumpRing("R5 ring");
    // payload then response
    runCmd(8'h03, 3, 4, 1, 8'h47, 1'b0);
    dumpRing("R4 ring");
    // long run wrapping the ring, host pokes ignored
    runCmd(8'h0B, 4, 6, 3, 8'h6C, 1'b1);
    dumpRing("R12 ring");
    // command code only: ring untouched
    runCmd(8'h06, 0, 0, 2, 8'h13, 1'b0);
    dumpRing("R6 ring");

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule